// File: doc/BRIEF.md
# PCM Voice TDM Serial Port

This block is the slave side of a time-division serial link that carries 8-bit voice samples between a line card and a telephony switch. An external master supplies the bit clock and a frame pulse. The port follows that timing and moves one byte in each direction through every active slot. The block runs on a fast local clock. It passes the bit clock, the frame pulse and the receive line through synchronizers, then reacts to the detected clock edges.

The frame pulse works as a level, not as a one-bit strobe. It rises together with the most significant bit of slot 0 and stays high for as long as valid bits are on the line. Slots are counted in bytes from the start of each frame. A window set by two configuration inputs picks which slots are live. Each received byte in the window comes out with a one-cycle strobe and its slot number. For transmit, the port shows the number of the slot whose byte it needs next, and the parallel side returns that byte. A frame pulse that falls part-way through a byte sets a sticky error flag.

Top module: `pcm_tdm_port`

## Requirements
- R1: After a synchronous reset, rx_valid, tx_oe and frame_err are all 0. frame_err stays 0 until a frame error occurs.
- R2: While fs_i is high, one receive bit is sampled on each falling edge of bclk_i. Bits are assembled MSB first. The MSB of slot 0 is the bit present at the first falling edge after fs_i rises, so there is no bit delay.
- R3: When the 8th bit of a slot is captured, rx_valid is high for exactly one clock cycle. rx_byte carries the byte and rx_slot carries the slot number, counted from 0 at the start of the frame.
- R4: A slot is live only if cfg_first <= slot <= cfg_last and slot < MAX_SLOTS (24). Slots outside that window raise neither rx_valid nor tx_oe.
- R5: tx_data sends the byte for slot k MSB first, and changes only after rising edges of bclk_i. The MSB of slot 0 is already on tx_data when fs_i rises. The byte for slot k is taken from tx_byte while tx_sel equals k (tx_sel is 0 between frames).
- R6: tx_oe is low whenever fs_i is low, and high during a live slot while fs_i is high.
- R7: If fs_i is low at a falling bclk_i edge after an incomplete byte, the partial byte produces no rx_valid, and frame_err is set. frame_err then stays set until reset.
- R8: A frame that ends on a byte boundary leaves frame_err unchanged, and the next frame numbers its slots from 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local fast clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | External bit clock from the master |
| fs_i | input | 1 | Level frame pulse, high during valid data |
| rxd_i | input | 1 | Serial receive data |
| cfg_first | input | 5 | First live slot |
| cfg_last | input | 5 | Last live slot |
| tx_byte | input | 8 | Transmit byte for slot tx_sel |
| tx_sel | output | 5 | Slot whose transmit byte is requested |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit line drive enable |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Received byte |
| rx_slot | output | 5 | Slot number of rx_byte |
| frame_err | output | 1 | Sticky flag for an incomplete byte |

## Verification
The assertions assume the bit clock is many local clock cycles per period, so that two received bytes are never less than two cycles apart. They also assume fs_i and rxd_i change only near rising bclk_i edges, so the synchronized values are stable at each falling edge. The bench drives a bit period of 16 local cycles. It changes fs_i and rxd_i at the same instant as the rising bclk_i edge, and it samples tx_data and tx_oe just before each falling edge, when the port's output settled long before. Frames of different lengths and slot windows are used, including frames that run past 24 slots and frames that stop mid-byte.

// File: rtl/pcm_tdm_pkg.sv
`timescale 1ns/1ps
package pcm_tdm_pkg;
  // Slot s is live when it lies inside the configured window and below the limit.
  function automatic logic in_window(input int unsigned s, input int unsigned lo,
                                     input int unsigned hi, input int unsigned lim);
    return (s >= lo) && (s <= hi) && (s < lim);
  endfunction
endpackage

// File: rtl/pcm_tdm_sync.sv
`timescale 1ns/1ps
module pcm_tdm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else if (i == 0) stage[i] <= d;
      else stage[i] <= stage[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pcm_tdm_rx.sv
`timescale 1ns/1ps
module pcm_tdm_rx #(
  parameter int SAMPLE_W  = 8,
  parameter int MAX_SLOTS = 24,
  parameter int SLOT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall_evt,
  input  logic                fs_s,
  input  logic                rxd_s,
  input  logic [SLOT_W-1:0]   cfg_first,
  input  logic [SLOT_W-1:0]   cfg_last,
  output logic                in_frame,
  output logic                byte_done,
  output logic                rx_valid,
  output logic [SAMPLE_W-1:0] rx_byte,
  output logic [SLOT_W-1:0]   rx_slot,
  output logic                frame_err
);
  import pcm_tdm_pkg::*;

  localparam int BIT_W = $clog2(SAMPLE_W);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(SAMPLE_W-1);
  localparam logic [SLOT_W-1:0] SLOT_SAT = {SLOT_W{1'b1}};

  logic [BIT_W-1:0]    bit_cnt;
  logic [SLOT_W-1:0]   slot_cnt;
  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] shreg_nxt;

  assign shreg_nxt = {shreg[SAMPLE_W-2:0], rxd_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame  <= 1'b0;
      bit_cnt   <= '0;
      slot_cnt  <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      rx_valid  <= 1'b0;
      rx_byte   <= '0;
      rx_slot   <= '0;
      frame_err <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      rx_valid  <= 1'b0;
      if (fall_evt) begin
        if (fs_s) begin
          in_frame <= 1'b1;
          shreg    <= shreg_nxt;
          if (bit_cnt == LAST_BIT) begin
            bit_cnt   <= '0;
            byte_done <= 1'b1;
            if (slot_cnt != SLOT_SAT) slot_cnt <= slot_cnt + 1'b1;
            if (in_window(32'(slot_cnt), 32'(cfg_first), 32'(cfg_last), MAX_SLOTS)) begin
              rx_valid <= 1'b1;
              rx_byte  <= shreg_nxt;
              rx_slot  <= slot_cnt;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          if (in_frame && bit_cnt != '0) frame_err <= 1'b1;
          in_frame <= 1'b0;
          bit_cnt  <= '0;
          slot_cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_tdm_tx.sv
`timescale 1ns/1ps
module pcm_tdm_tx #(
  parameter int SAMPLE_W  = 8,
  parameter int MAX_SLOTS = 24,
  parameter int SLOT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise_evt,
  input  logic                fs_s,
  input  logic                in_frame,
  input  logic                byte_done,
  input  logic [SLOT_W-1:0]   cfg_first,
  input  logic [SLOT_W-1:0]   cfg_last,
  input  logic [SAMPLE_W-1:0] tx_byte,
  output logic [SLOT_W-1:0]   tx_sel,
  output logic                tx_data,
  output logic                tx_oe
);
  import pcm_tdm_pkg::*;

  localparam logic [SLOT_W-1:0] SLOT_SAT = {SLOT_W{1'b1}};

  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] pend_byte;
  logic                pend;
  logic [SLOT_W-1:0]   out_slot;
  logic [SLOT_W-1:0]   out_slot_inc;

  assign out_slot_inc = (out_slot == SLOT_SAT) ? SLOT_SAT : out_slot + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      pend_byte <= '0;
      pend      <= 1'b0;
      out_slot  <= '0;
      tx_sel    <= '0;
      tx_oe     <= 1'b0;
    end else begin
      tx_sel <= in_frame ? out_slot_inc : '0;
      tx_oe  <= fs_s && in_window(32'(out_slot), 32'(cfg_first), 32'(cfg_last), MAX_SLOTS);
      if (!in_frame) begin
        shreg    <= tx_byte;
        pend     <= 1'b0;
        out_slot <= '0;
      end else begin
        if (byte_done) begin
          pend      <= 1'b1;
          pend_byte <= tx_byte;
        end
        if (rise_evt) begin
          if (pend) begin
            shreg    <= pend_byte;
            pend     <= 1'b0;
            out_slot <= out_slot_inc;
          end else begin
            shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign tx_data = shreg[SAMPLE_W-1];
endmodule

// File: rtl/pcm_tdm_port.sv
`timescale 1ns/1ps
module pcm_tdm_port #(
  parameter int SAMPLE_W    = 8,
  parameter int MAX_SLOTS   = 24,
  parameter int SLOT_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_i,
  input  logic                fs_i,
  input  logic                rxd_i,
  input  logic [SLOT_W-1:0]   cfg_first,
  input  logic [SLOT_W-1:0]   cfg_last,
  input  logic [SAMPLE_W-1:0] tx_byte,
  output logic [SLOT_W-1:0]   tx_sel,
  output logic                tx_data,
  output logic                tx_oe,
  output logic                rx_valid,
  output logic [SAMPLE_W-1:0] rx_byte,
  output logic [SLOT_W-1:0]   rx_slot,
  output logic                frame_err
);
  logic [2:0] pins_s;
  logic       bclk_s, fs_s, rxd_s, bclk_d;
  logic       rise_evt, fall_evt;
  logic       in_frame, byte_done;

  pcm_tdm_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d({bclk_i, fs_i, rxd_i}), .q(pins_s)
  );

  assign {bclk_s, fs_s, rxd_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) bclk_d <= 1'b0;
    else     bclk_d <= bclk_s;
  end

  assign rise_evt = bclk_s && !bclk_d;
  assign fall_evt = !bclk_s && bclk_d;

  pcm_tdm_rx #(.SAMPLE_W(SAMPLE_W), .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) rx_i (
    .clk(clk), .rst(rst), .fall_evt(fall_evt), .fs_s(fs_s), .rxd_s(rxd_s),
    .cfg_first(cfg_first), .cfg_last(cfg_last), .in_frame(in_frame),
    .byte_done(byte_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_slot(rx_slot), .frame_err(frame_err)
  );

  pcm_tdm_tx #(.SAMPLE_W(SAMPLE_W), .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) tx_i (
    .clk(clk), .rst(rst), .rise_evt(rise_evt), .fs_s(fs_s), .in_frame(in_frame),
    .byte_done(byte_done), .cfg_first(cfg_first), .cfg_last(cfg_last),
    .tx_byte(tx_byte), .tx_sel(tx_sel), .tx_data(tx_data), .tx_oe(tx_oe)
  );
endmodule

// File: rtl/pcm_tdm_port_chk.sv
`timescale 1ns/1ps
module pcm_tdm_port_chk #(
  parameter int SAMPLE_W  = 8,
  parameter int MAX_SLOTS = 24,
  parameter int SLOT_W    = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                fs_i,
  input logic [SLOT_W-1:0]   cfg_first,
  input logic [SLOT_W-1:0]   cfg_last,
  input logic                tx_oe,
  input logic                rx_valid,
  input logic [SAMPLE_W-1:0] rx_byte,
  input logic [SLOT_W-1:0]   rx_slot,
  input logic                frame_err
);
  // R3
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R4
  rx_slot_window_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_slot >= cfg_first && rx_slot <= cfg_last && int'(rx_slot) < MAX_SLOTS));

  // R6 (window of 3 matches the default two-stage synchronizer plus output register)
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!fs_i && $past(!fs_i) && $past(!fs_i, 2) && $past(!fs_i, 3)) |-> !tx_oe);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);

  // R3
  rx_known_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !$isunknown(rx_byte));
endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(
  .SAMPLE_W(SAMPLE_W), .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)
) chk_i (
  .clk(clk), .rst(rst), .fs_i(fs_i), .cfg_first(cfg_first), .cfg_last(cfg_last),
  .tx_oe(tx_oe), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_slot(rx_slot),
  .frame_err(frame_err)
);

// File: tb/pcm_tdm_port_tb_top.sv
`timescale 1ns/1ps
module pcm_tdm_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk_i = 1'b0, fs_i = 1'b0, rxd_i = 1'b1;
  logic [4:0] cfg_first = '0, cfg_last = 5'd31;
  logic [7:0] tx_byte;
  logic [4:0] tx_sel, rx_slot;
  logic       tx_data, tx_oe, rx_valid, frame_err;
  logic [7:0] rx_byte;

  int n_chk = 0;
  int n_bad = 0;
  logic [12:0] exp_q[$];
  logic        s_oe, s_tx;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] tx_pat(input int s);
    return 8'((s * 29 + 8'h5A) & 8'hFF);
  endfunction

  function automatic logic [7:0] rx_pat(input int s, input int seed);
    return 8'((s * 53 + seed * 17 + 8'hC3) & 8'hFF);
  endfunction

  assign tx_byte = tx_pat(int'(tx_sel));

  pcm_tdm_port dut_i (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .fs_i(fs_i), .rxd_i(rxd_i),
    .cfg_first(cfg_first), .cfg_last(cfg_last), .tx_byte(tx_byte), .tx_sel(tx_sel),
    .tx_data(tx_data), .tx_oe(tx_oe), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_slot(rx_slot), .frame_err(frame_err)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops expected receive bytes as the design produces them (R2, R3)
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R7 unexpected rx_valid", {rx_slot, rx_byte}, 0);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        check({rx_slot, rx_byte} == e, "R2/R3 rx slot+byte", {rx_slot, rx_byte}, e);
      end
    end
  end

  // One bit period of 16 local cycles; master changes fs/rxd with the rising edge.
  task automatic bit_cyc(input logic f, input logic d);
    bclk_i = 1'b1; fs_i = f; rxd_i = d;
    #38;
    s_oe = tx_oe; s_tx = tx_data;
    #2 bclk_i = 1'b0;
    #40;
  endtask

  function automatic logic live(input int s);
    return s >= int'(cfg_first) && s <= int'(cfg_last) && s < 24;
  endfunction

  task automatic run_frame(input int nbytes, input int extra, input int seed);
    for (int k = 0; k <= nbytes; k++) begin
      logic [7:0] b;
      int nb;
      b  = rx_pat(k, seed);
      nb = (k < nbytes) ? 8 : extra;
      if (k < nbytes && live(k)) exp_q.push_back({5'(k), b});
      for (int j = 0; j < nb; j++) begin
        bit_cyc(1'b1, b[7-j]);
        check(s_oe == live(k), "R4/R6 tx_oe in slot", s_oe, live(k));
        if (live(k)) check(s_tx == tx_pat(k)[7-j], "R5 tx bit", s_tx, tx_pat(k)[7-j]);
      end
    end
    for (int i = 0; i < 2; i++) begin
      bit_cyc(1'b0, 1'b1);
      check(s_oe == 1'b0, "R6 tx_oe idle", s_oe, 0);
    end
    #100;
    check(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (10) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(rx_valid == 0, "R1 rx_valid reset", rx_valid, 0);
    check(tx_oe == 0, "R1 tx_oe reset", tx_oe, 0);
    check(frame_err == 0, "R1 frame_err reset", frame_err, 0);
    check(tx_sel == 0, "R5 tx_sel idle", tx_sel, 0);

    cfg_first = 5'd0; cfg_last = 5'd31;
    run_frame(4, 0, 1);
    cfg_first = 5'd0; cfg_last = 5'd23;
    run_frame(24, 0, 2);
    cfg_first = 5'd20; cfg_last = 5'd31;
    run_frame(26, 0, 3);   // R4: slots 24, 25 beyond limit
    cfg_first = 5'd2; cfg_last = 5'd3;
    run_frame(6, 0, 4);
    check(frame_err == 0, "R8 clean frames keep no error", frame_err, 0);

    cfg_first = 5'd0; cfg_last = 5'd31;
    run_frame(3, 5, 5);    // R7: drop mid-byte
    check(frame_err == 1, "R7 frame_err set", frame_err, 1);
    run_frame(2, 0, 6);    // R8: restarts at slot 0
    check(frame_err == 1, "R7 frame_err sticky", frame_err, 1);

    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk); #1 rst = 1'b0;
    @(posedge clk); #1;
    check(frame_err == 0, "R1 frame_err cleared by reset", frame_err, 0);
    run_frame(1, 0, 7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule